// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block tells a DDR SDRAM controller when to issue auto-refresh commands. A free-running interval timer adds one owed refresh each time the average refresh period elapses. The debt stays pending until a command arbiter grants a slot. The debt saturates at a fixed ceiling. An urgent flag warns the arbiter one step before that ceiling. Each issued refresh starts a refresh-cycle window. During this window new activates and refreshes are held off, and a completion pulse marks its end.

The same block also handles self-refresh. It enters self-refresh only when nothing is owed and all banks are idle, and it holds clock-enable low while in that state. On exit it raises clock-enable and applies two separate waits: a shorter one for non-read commands and a longer one for reads. All timing values are given in picoseconds or cycles. The block converts them to whole clock cycles by rounding up.

The finite-state machine has five states. IDLE waits for work. REQ asks for a refresh slot. RFC is the refresh-cycle wait. SR is self-refresh. XS is the self-refresh exit wait. The transitions are:
- IDLE→REQ when debt is non-zero.
- IDLE→SR on an entry request with banks idle and zero debt.
- REQ→RFC when the grant arrives with banks idle; the refresh fires in that cycle.
- RFC→IDLE after the last refresh-cycle count.
- SR→XS on an exit request.
- XS→IDLE after the read exit wait.

Top module: `refresh_sched`

## Requirements
- R1: While reset is applied and immediately after its release, `cke` is 1 and `ref_req`, `ref_urgent`, `ref_fire`, `ref_done`, `hold_read` and `hold_nonread` are 0.
- R2: After reset release, the first owed refresh accrues at the end of interval cycle N, where N = ceil(TREFI_PS/CLK_PS). `ref_req` is 0 after N rising edges and 1 after N+1 edges.
- R3: `ref_fire` is 1 only in a cycle where `ref_req`, `ref_gnt` and `banks_idle` are all 1. While the banks are busy, a grant has no effect and `ref_req` stays 1.
- R4: After a fire, `hold_nonread` is 1 for exactly ceil(TRFC_PS/CLK_PS) cycles, and `ref_done` is 1 in the last of those cycles only. No second fire can occur within that window.
- R5: Debt saturates at MAX_OWED. If grants are withheld for more than MAX_OWED intervals, the following drain yields exactly MAX_OWED fires.
- R6: `ref_urgent` is 1 while requesting with debt of at least MAX_OWED-1, and 0 when the debt is one.
- R7: Self-refresh is entered only from IDLE, with `sr_enter`, `banks_idle` and zero debt. In the next cycle `cke` is 0 and both holds are 1. A busy bank or a pending refresh leaves `cke` at 1.
- R8: After `sr_exit`, `cke` returns to 1. `hold_nonread` stays 1 for ceil(TXSNR_PS/CLK_PS) cycles, and `hold_read` stays 1 for TXSRD_CYC cycles.
- R9: The interval timer is stopped and cleared during self-refresh, so no debt accrues there. After exit, the next request waits a full interval measured from the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_gnt | input | 1 | Arbiter grants the refresh slot |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh slot requested |
| ref_urgent | output | 1 | Debt is near the ceiling |
| ref_fire | output | 1 | Issue auto-refresh in this cycle |
| ref_done | output | 1 | Last cycle of the refresh-cycle window |
| cke | output | 1 | DRAM clock enable |
| hold_nonread | output | 1 | Block activate, refresh and other non-read commands |
| hold_read | output | 1 | Block read commands |

## Verification
The bench builds the block with a 4000 ps clock and the following settings:
- TREFI_PS=240000, giving a 60-cycle interval.
- TRFC_PS=30000, which is 7.5 cycles and rounds up to 8.
- TXSNR_PS=50000, which is 12.5 cycles and rounds up to 13.
- TXSRD_CYC=40.
- MAX_OWED=4.

The short interval lets the test withhold grants for six intervals and still drain the saturated debt before the next expiry. This makes the ceiling visible in a fire count. The non-integer ratios check the round-up rule at both edges of the refresh and exit windows. Because the read exit wait is shorter than one interval, any debt accrued during self-refresh would show up as a request right after exit.

// File: rtl/refresh_sched_pkg.sv
`timescale 1ns/1ps
package refresh_sched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RFC,
        ST_SR,
        ST_XS
    } rs_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/refresh_sched_ivl.sv
`timescale 1ns/1ps
// Interval timer: pulses tick once every CYC running cycles, cleared while stopped.
module refresh_sched_ivl #(
    parameter int CYC = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(CYC + 1);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == W'(CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refresh_sched_debt.sv
`timescale 1ns/1ps
// Owed-refresh counter, saturating at MAX.
module refresh_sched_debt #(
    parameter int MAX = 8,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] owed
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (owed != W'(MAX)) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)      owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/refresh_sched_span.sv
`timescale 1ns/1ps
// Phase cycle counter: zero while clr, otherwise counts up and saturates.
module refresh_sched_span #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int CLK_PS    = 7500,
    parameter int TREFI_PS  = 7800000,
    parameter int TRFC_PS   = 75000,
    parameter int TXSNR_PS  = 75000,
    parameter int TXSRD_CYC = 200,
    parameter int MAX_OWED  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle,
    input  logic ref_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_fire,
    output logic ref_done,
    output logic cke,
    output logic hold_nonread,
    output logic hold_read
);
    localparam int IVL_CYC  = ceil_div(TREFI_PS, CLK_PS);
    localparam int RFC_CYC  = ceil_div(TRFC_PS, CLK_PS);
    localparam int XSNR_CYC = ceil_div(TXSNR_PS, CLK_PS);
    localparam int URG_AT   = MAX_OWED - 1;
    localparam int OW       = $clog2(MAX_OWED + 1);
    localparam int SPAN_MAX = (RFC_CYC > TXSRD_CYC) ? RFC_CYC : TXSRD_CYC;
    localparam int SW       = $clog2(SPAN_MAX + 1);

    rs_state_e state, state_nx;
    logic          ivl_tick;
    logic [OW-1:0] owed;
    logic [SW-1:0] rfc_cnt, xs_cnt;
    logic          rfc_last, xs_last;

    refresh_sched_ivl #(.CYC(IVL_CYC)) u_ivl (
        .clk(clk), .rst_n(rst_n), .run(state != ST_SR), .tick(ivl_tick)
    );

    refresh_sched_debt #(.MAX(MAX_OWED), .W(OW)) u_debt (
        .clk(clk), .rst_n(rst_n), .inc(ivl_tick), .dec(ref_fire), .owed(owed)
    );

    refresh_sched_span #(.W(SW)) u_rfc_span (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_RFC), .cnt(rfc_cnt)
    );

    refresh_sched_span #(.W(SW)) u_xs_span (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_XS), .cnt(xs_cnt)
    );

    assign rfc_last = (rfc_cnt == SW'(RFC_CYC - 1));
    assign xs_last  = (xs_cnt == SW'(TXSRD_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (owed != '0)                   state_nx = ST_REQ;
                else if (sr_enter && banks_idle)  state_nx = ST_SR;
            end
            ST_REQ:  if (ref_gnt && banks_idle)   state_nx = ST_RFC;
            ST_RFC:  if (rfc_last)                state_nx = ST_IDLE;
            ST_SR:   if (sr_exit)                 state_nx = ST_XS;
            ST_XS:   if (xs_last)                 state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ref_req      = 1'b0;
        ref_urgent   = 1'b0;
        ref_fire     = 1'b0;
        ref_done     = 1'b0;
        cke          = 1'b1;
        hold_nonread = 1'b0;
        hold_read    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_REQ: begin
                ref_req    = 1'b1;
                ref_urgent = (owed >= OW'(URG_AT));
                ref_fire   = ref_gnt && banks_idle;
            end
            ST_RFC: begin
                hold_nonread = 1'b1;
                ref_done     = rfc_last;
            end
            ST_SR: begin
                cke          = 1'b0;
                hold_nonread = 1'b1;
                hold_read    = 1'b1;
            end
            ST_XS: begin
                hold_nonread = (xs_cnt < SW'(XSNR_CYC));
                hold_read    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
    parameter int RFC_CYC = 10
) (
    input logic clk,
    input logic rst_n,
    input logic banks_idle,
    input logic ref_gnt,
    input logic ref_req,
    input logic ref_urgent,
    input logic ref_fire,
    input logic cke,
    input logic hold_nonread,
    input logic hold_read
);
    logic [15:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (ref_fire) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 1'b1;
        end
    end

    assert_fire_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |-> (ref_req && ref_gnt && banks_idle));

    assert_rfc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |=> (hold_nonread && !ref_fire));

    assert_rfc_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |-> (!seen || (32'(gap) + 1 >= RFC_CYC)));

    assert_urgent_in_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    assert_sr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (hold_read && hold_nonread && !ref_req));

    assert_exit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (hold_read && hold_nonread));
endmodule

bind refresh_sched refresh_sched_chk #(.RFC_CYC(RFC_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_fire(ref_fire),
    .cke(cke), .hold_nonread(hold_nonread), .hold_read(hold_read)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
    localparam int IVL  = 60;
    localparam int RFC  = 8;
    localparam int XSNR = 13;
    localparam int XSRD = 40;
    localparam int MAXO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b1, ref_gnt = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_req, ref_urgent, ref_fire, ref_done, cke, hold_nonread, hold_read;
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    refresh_sched #(
        .CLK_PS(4000), .TREFI_PS(240000), .TRFC_PS(30000),
        .TXSNR_PS(50000), .TXSRD_CYC(XSRD), .MAX_OWED(MAXO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_gnt(ref_gnt),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_fire(ref_fire), .ref_done(ref_done),
        .cke(cke), .hold_nonread(hold_nonread), .hold_read(hold_read)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; banks_idle = 1'b1; ref_gnt = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_R1();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) step();
        chk("R1 cke in reset", int'(cke), 1);
        chk("R1 req in reset", int'(ref_req), 0);
        chk("R1 holds in reset", int'(hold_read | hold_nonread), 0);
        do_reset();
        #1;
        chk("R1 outputs after release",
            int'({ref_req, ref_urgent, ref_fire, ref_done, hold_read, hold_nonread}), 0);
        chk("R1 cke after release", int'(cke), 1);
    endtask

    task automatic t_interval_R2_R3_R4();
        do_reset();
        repeat (IVL) step();
        chk("R2 no request before interval", int'(ref_req), 0);
        step();
        chk("R2 request after interval", int'(ref_req), 1);
        chk("R6 not urgent with one owed", int'(ref_urgent), 0);
        banks_idle = 1'b0; ref_gnt = 1'b1; #1;
        chk("R3 no fire while banks busy", int'(ref_fire), 0);
        repeat (3) step();
        chk("R3 request kept while busy", int'(ref_req), 1);
        chk("R3 still no fire", int'(ref_fire), 0);
        banks_idle = 1'b1; #1;
        chk("R3 fire on grant and idle", int'(ref_fire), 1);
        for (int j = 1; j <= RFC; j++) begin
            step();
            if (j == 1 || j == RFC) begin
                chk("R4 hold during refresh cycle", int'(hold_nonread), 1);
                chk("R4 done only in last cycle", int'(ref_done), (j == RFC) ? 1 : 0);
            end
            chk("R4 no fire in window", int'(ref_fire), 0);
        end
        step();
        chk("R4 hold released after window", int'(hold_nonread), 0);
        ref_gnt = 1'b0;
    endtask

    task automatic t_ceiling_R5_R6();
        int fires = 0;
        do_reset();
        repeat (6 * IVL + 2) step();
        chk("R6 urgent near ceiling", int'(ref_urgent), 1);
        ref_gnt = 1'b1;
        for (int k = 0; k < 55; k++) begin
            #1;
            if (ref_fire) fires++;
            step();
        end
        chk("R5 drain limited to ceiling", fires, MAXO);
        chk("R5 debt cleared after drain", int'(ref_req), 0);
        ref_gnt = 1'b0;
    endtask

    task automatic t_selfref_R7_R8_R9();
        do_reset();
        banks_idle = 1'b0; sr_enter = 1'b1;
        repeat (3) step();
        chk("R7 no entry with busy banks", int'(cke), 1);
        banks_idle = 1'b1;
        step();
        chk("R7 cke low in self-refresh", int'(cke), 0);
        chk("R7 holds in self-refresh", int'(hold_read & hold_nonread), 1);
        sr_enter = 1'b0;
        repeat (4 * IVL) step();
        chk("R9 no request during self-refresh", int'(ref_req), 0);
        chk("R7 cke stays low", int'(cke), 0);
        sr_exit = 1'b1;
        step();
        sr_exit = 1'b0;
        chk("R8 cke high after exit", int'(cke), 1);
        for (int j = 2; j <= XSRD + 1; j++) begin
            step();
            if (j == XSNR)     chk("R8 nonread held last cycle", int'(hold_nonread), 1);
            if (j == XSNR + 1) chk("R8 nonread released", int'(hold_nonread), 0);
            if (j == XSRD)     chk("R8 read held last cycle", int'(hold_read), 1);
            if (j == XSRD + 1) chk("R8 read released", int'(hold_read), 0);
        end
        repeat (10) step();
        chk("R9 no debt carried from self-refresh", int'(ref_req), 0);
        do_reset();
        repeat (IVL + 2) step();
        sr_enter = 1'b1;
        repeat (3) step();
        chk("R7 no entry while refresh owed", int'(cke), 1);
        chk("R7 request persists", int'(ref_req), 1);
        sr_enter = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset_R1();
        t_interval_R2_R3_R4();
        t_ceiling_R5_R6();
        t_selfref_R7_R8_R9();
        summary();
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end
endmodule